// File: doc/BRIEF.md
# Eight-bit accumulator ALU

A purely combinational arithmetic and logic unit for a small accumulator-style microcontroller datapath. It combines two operands, A and B, under a 4-bit operation code and returns a result together with a carry-out and a zero flag. The carry-in comes from the carry bit of the surrounding status register. The unit itself keeps no state.

Higher-level operations are built by the surrounding datapath from the nine primitives. A register move is an OR with a zero operand. Increment and decrement are ADD and SUB with B tied to the constant 1. Bit set, clear and test use a one-hot mask, inverted where needed, that is combined by AND or OR. Flag write enables, operand selection and the status register sit outside this block.

Top module: `acc_alu`

## Requirements
- R1: Opcode 4'b0000 (ADD) gives y = (A + B) mod 256 and cout = 1 exactly when A + B exceeds 255. cin does not affect either output.
- R2: Opcode 4'b1000 (SUB) gives y = (A - B) mod 256. cout is the inverted borrow, so it is 1 exactly when A >= B.
- R3: Opcodes 4'b0001 (AND), 4'b0010 (OR) and 4'b0011 (XOR) give the bitwise function of A and B with cout = cin. OR with B = 0 returns A unchanged.
- R4: ADD and SUB with B = 1 act as increment and decrement: 0xFF+1 gives 0x00 with cout=1, and 0x00-1 gives 0xFF with cout=0.
- R5: Opcode 4'b0100 (COM) gives y = ~A with cout = cin.
- R6: Opcode 4'b0101 (ROR) shifts A right by one. cin enters bit 7 and bit 0 of A leaves as cout.
- R7: Opcode 4'b0110 (ROL) shifts A left by one. cin enters bit 0 and bit 7 of A leaves as cout.
- R8: Opcode 4'b0111 (SWAP) exchanges the upper and lower nibbles of A, with cout = cin.
- R9: zero is 1 exactly when all 8 bits of y are 0, for every opcode.
- R10: Opcodes 4'b1001 through 4'b1111 give y = 0 with cout = cin, and therefore zero = 1.
- R11: A one-hot mask on A combined by OR sets exactly that bit of B. An inverted one-hot mask combined by AND clears exactly that bit of B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| a | input | 8 | Operand A (mask operand for bit operations) |
| b | input | 8 | Operand B |
| cin | input | 1 | Carry bit from the status register |
| y | output | 8 | Result |
| cout | output | 1 | Carry out (inverted borrow for SUB) |
| zero | output | 1 | High when the result is all zeros |

## Verification
The bench targets the carry boundaries.

- ADD is exercised at 0xFF+1 and 0x80+0x80. A design that uses cin in the addition, or drops the ninth sum bit, reports a wrong sum or a wrong carry there.
- SUB is exercised at equal operands and at 0x00-1. A design that returns the raw borrow instead of its inverse shows up in both cases.
- The rotates are exercised with cin opposite to the bit being shifted out. A design that wires the ring backwards, or rotates without going through the carry, yields the wrong edge bits.
- The unused opcodes are exercised with both values of cin. A design that falls through to another operation, or clears the carry on those codes, is caught.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_AND  = 4'b0001,
    OP_OR   = 4'b0010,
    OP_XOR  = 4'b0011,
    OP_COM  = 4'b0100,
    OP_ROR  = 4'b0101,
    OP_ROL  = 4'b0110,
    OP_SWAP = 4'b0111,
    OP_SUB  = 4'b1000
  } alu_op_e;

  localparam int OP_BITS = 4;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             sum_carry,
  output logic [WIDTH-1:0] diff,
  output logic             diff_noborrow
);
  localparam int EXT = WIDTH + 1;

  function automatic logic [EXT-1:0] add_ext(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] z);
    return {1'b0, x} + {1'b0, z};
  endfunction

  function automatic logic [EXT-1:0] sub_ext(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] z);
    return {1'b0, x} - {1'b0, z};
  endfunction

  logic [EXT-1:0] add_full;
  logic [EXT-1:0] sub_full;
  logic           sub_borrow;

  always_comb begin
    add_full      = add_ext(a, b);
    sub_full      = sub_ext(a, b);
    sub_borrow    = sub_full[WIDTH];
    sum           = add_full[WIDTH-1:0];
    sum_carry     = add_full[WIDTH];
    diff          = sub_full[WIDTH-1:0];
    diff_noborrow = ~sub_borrow;
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] and_r,
  output logic [WIDTH-1:0] or_r,
  output logic [WIDTH-1:0] xor_r,
  output logic [WIDTH-1:0] com_r,
  output logic [WIDTH-1:0] swap_r
);
  localparam int HALF = WIDTH / 2;

  function automatic logic [WIDTH-1:0] halves_swapped(input logic [WIDTH-1:0] x);
    return {x[HALF-1:0], x[WIDTH-1:HALF]};
  endfunction

  always_comb begin
    and_r  = a & b;
    or_r   = a | b;
    xor_r  = a ^ b;
    com_r  = ~a;
    swap_r = halves_swapped(a);
  end
endmodule

// File: rtl/acc_alu_rotate.sv
module acc_alu_rotate #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic             cin,
  output logic [WIDTH-1:0] ror_r,
  output logic             ror_c,
  output logic [WIDTH-1:0] rol_r,
  output logic             rol_c
);
  function automatic logic [WIDTH:0] right_through(input logic [WIDTH-1:0] x, input logic c);
    return {x[0], c, x[WIDTH-1:1]};
  endfunction

  function automatic logic [WIDTH:0] left_through(input logic [WIDTH-1:0] x, input logic c);
    return {x, c};
  endfunction

  logic [WIDTH:0] ror_full;
  logic [WIDTH:0] rol_full;

  always_comb begin
    ror_full = right_through(a, cin);
    rol_full = left_through(a, cin);
    ror_c    = ror_full[WIDTH];
    ror_r    = ror_full[WIDTH-1:0];
    rol_c    = rol_full[WIDTH];
    rol_r    = rol_full[WIDTH-1:0];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] y,
  output logic             cout,
  output logic             zero
);
  import acc_alu_pkg::*;

  logic [WIDTH-1:0] sum, diff, and_r, or_r, xor_r, com_r, swap_r, ror_r, rol_r;
  logic             sum_carry, diff_noborrow, ror_c, rol_c;
  logic             op_known;

  acc_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .a(a), .b(b), .sum(sum), .sum_carry(sum_carry),
    .diff(diff), .diff_noborrow(diff_noborrow)
  );

  acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a(a), .b(b), .and_r(and_r), .or_r(or_r), .xor_r(xor_r),
    .com_r(com_r), .swap_r(swap_r)
  );

  acc_alu_rotate #(.WIDTH(WIDTH)) u_rot (
    .a(a), .cin(cin), .ror_r(ror_r), .ror_c(ror_c),
    .rol_r(rol_r), .rol_c(rol_c)
  );

  always_comb begin
    y        = '0;
    cout     = cin;
    op_known = 1'b1;
    case (op)
      OP_ADD:  begin y = sum;    cout = sum_carry;     end
      OP_SUB:  begin y = diff;   cout = diff_noborrow; end
      OP_AND:  y = and_r;
      OP_OR:   y = or_r;
      OP_XOR:  y = xor_r;
      OP_COM:  y = com_r;
      OP_SWAP: y = swap_r;
      OP_ROR:  begin y = ror_r;  cout = ror_c;         end
      OP_ROL:  begin y = rol_r;  cout = rol_c;         end
      default: op_known = 1'b0;
    endcase
    zero = ~|y;
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [3:0]       op,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] y,
  input logic             cout,
  input logic             zero,
  input logic             op_known
);
  localparam int HALF = WIDTH / 2;

  always_comb begin
    assert_zero_flag_R9: assert (zero == (y == '0));
    if (op == 4'b0000) begin
      assert_add_carry_R1: assert (cout == (a > ~b));
      assert_add_sum_R1: assert (WIDTH'(y - b) == a);
    end
    if (op == 4'b1000) begin
      assert_sub_noborrow_R2: assert (cout == (a >= b));
      assert_sub_diff_R2: assert (WIDTH'(y + b) == a);
    end
    if (op == 4'b0001 || op == 4'b0010 || op == 4'b0011) begin
      assert_logic_keeps_carry_R3: assert (cout == cin);
    end
    if (op == 4'b0100) begin
      assert_com_R5: assert (((y ^ a) == '1) && (cout == cin));
    end
    if (op == 4'b0101) begin
      assert_ror_edges_R6: assert ((cout == a[0]) && (y[WIDTH-1] == cin));
    end
    if (op == 4'b0110) begin
      assert_rol_edges_R7: assert ((cout == a[WIDTH-1]) && (y[0] == cin));
    end
    if (op == 4'b0111) begin
      assert_swap_R8: assert ((y[WIDTH-1:HALF] == a[HALF-1:0]) && (y[HALF-1:0] == a[WIDTH-1:HALF]) && (cout == cin));
    end
    if (op > 4'b1000) begin
      assert_unused_op_R10: assert (!op_known && (y == '0) && (cout == cin) && zero);
    end
  end
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .op(op), .a(a), .b(b), .cin(cin), .y(y), .cout(cout), .zero(zero), .op_known(op_known)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic       clk = 1'b0;
  logic [3:0] op  = 4'b0000;
  logic [7:0] a   = 8'h00;
  logic [7:0] b   = 8'h00;
  logic       cin = 1'b0;
  logic [7:0] y;
  logic       cout, zero;
  int         checks = 0;
  int         fails  = 0;

  always #10 clk = ~clk;

  acc_alu u_acc_alu (.op(op), .a(a), .b(b), .cin(cin), .y(y), .cout(cout), .zero(zero));

  // {req, op, a, b, cin, y, cout, zero}
  localparam int NV = 22;
  localparam logic [34:0] VEC [NV] = '{
    {4'd1,  4'b0000, 8'h12, 8'h34, 1'b0, 8'h46, 1'b0, 1'b0}, // R1
    {4'd4,  4'b0000, 8'hFF, 8'h01, 1'b1, 8'h00, 1'b1, 1'b1}, // R4
    {4'd1,  4'b0000, 8'h80, 8'h80, 1'b0, 8'h00, 1'b1, 1'b1}, // R1
    {4'd2,  4'b1000, 8'h34, 8'h12, 1'b0, 8'h22, 1'b1, 1'b0}, // R2
    {4'd2,  4'b1000, 8'h12, 8'h34, 1'b1, 8'hDE, 1'b0, 1'b0}, // R2
    {4'd2,  4'b1000, 8'h55, 8'h55, 1'b0, 8'h00, 1'b1, 1'b1}, // R2
    {4'd4,  4'b1000, 8'h00, 8'h01, 1'b1, 8'hFF, 1'b0, 1'b0}, // R4
    {4'd3,  4'b0001, 8'hF0, 8'h3C, 1'b1, 8'h30, 1'b1, 1'b0}, // R3
    {4'd3,  4'b0010, 8'h00, 8'hA5, 1'b0, 8'hA5, 1'b0, 1'b0}, // R3 copy
    {4'd3,  4'b0011, 8'hAA, 8'hAA, 1'b1, 8'h00, 1'b1, 1'b1}, // R3
    {4'd5,  4'b0100, 8'h0F, 8'h77, 1'b0, 8'hF0, 1'b0, 1'b0}, // R5
    {4'd5,  4'b0100, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1}, // R5
    {4'd6,  4'b0101, 8'h81, 8'h00, 1'b0, 8'h40, 1'b1, 1'b0}, // R6
    {4'd6,  4'b0101, 8'h02, 8'h00, 1'b1, 8'h81, 1'b0, 1'b0}, // R6
    {4'd7,  4'b0110, 8'h81, 8'h00, 1'b0, 8'h02, 1'b1, 1'b0}, // R7
    {4'd7,  4'b0110, 8'h40, 8'h00, 1'b1, 8'h81, 1'b0, 1'b0}, // R7
    {4'd9,  4'b0110, 8'h80, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1}, // R9
    {4'd8,  4'b0111, 8'h3C, 8'h00, 1'b1, 8'hC3, 1'b1, 1'b0}, // R8
    {4'd11, 4'b0001, 8'hFB, 8'h0C, 1'b0, 8'h08, 1'b0, 1'b0}, // R11 clear
    {4'd11, 4'b0010, 8'h10, 8'h01, 1'b1, 8'h11, 1'b1, 1'b0}, // R11 set
    {4'd10, 4'b1001, 8'hFF, 8'hFF, 1'b1, 8'h00, 1'b1, 1'b1}, // R10
    {4'd10, 4'b1111, 8'h5A, 8'hA5, 1'b0, 8'h00, 1'b0, 1'b1}  // R10
  };

  function automatic logic [9:0] model(input logic [3:0] o, input logic [7:0] x,
                                       input logic [7:0] z, input logic c);
    int s;
    int r;
    logic k;
    k = c;
    r = 0;
    case (o)
      4'b0000: begin s = int'(x) + int'(z); r = s % 256; k = (s > 255); end
      4'b1000: begin r = (int'(x) + 256 - int'(z)) % 256; k = (x >= z); end
      4'b0001: r = int'(x & z);
      4'b0010: r = int'(x | z);
      4'b0011: r = int'(x ^ z);
      4'b0100: r = 255 - int'(x);
      4'b0101: begin r = int'(x) / 2 + (c ? 128 : 0); k = x[0]; end
      4'b0110: begin r = (int'(x) * 2) % 256 + (c ? 1 : 0); k = x[7]; end
      4'b0111: r = (int'(x) % 16) * 16 + int'(x) / 16;
      default: r = 0;
    endcase
    return {r[7:0], k, (r == 0)};
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'b0000: return "R1";
      4'b1000: return "R2";
      4'b0001, 4'b0010, 4'b0011: return "R3";
      4'b0100: return "R5";
      4'b0101: return "R6";
      4'b0110: return "R7";
      4'b0111: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic compare(input string rq, input logic [9:0] exp);
    checks++;
    if ({y, cout, zero} !== exp) begin
      fails++;
      $display("FAIL %s op=%b a=%h b=%h cin=%b: got y=%h c=%b z=%b, expected y=%h c=%b z=%b",
               rq, op, a, b, cin, y, cout, zero, exp[9:2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [7:0] x, input logic [7:0] z, input logic c);
    @(posedge clk);
    op = o; a = x; b = z; cin = c;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    @(negedge clk);
    // idle state: all inputs zero, ADD gives zero result with zero flag (R9)
    compare("R9", {8'h00, 1'b0, 1'b1});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][30:27], VEC[i][26:19], VEC[i][18:11], VEC[i][10]);
      compare($sformatf("R%0d", VEC[i][34:31]), VEC[i][9:0]);
    end

    // sweep every opcode against the bench model, both carry-in values
    lf = 8'h5B;
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 40; n++) begin
        logic [7:0] xa;
        logic [7:0] xb;
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        xa = lf;
        xb = {lf[3:0], lf[7:4]} ^ 8'h3D;
        if (n == 0) begin xa = 8'hFF; xb = 8'hFF; end
        if (n == 1) begin xa = 8'h00; xb = 8'h00; end
        apply(4'(o), xa, xb, n[0]);
        compare(req_of(4'(o)), model(4'(o), xa, xb, n[0]));
      end
    end

    // R4: increment / decrement wrap with B tied to one
    apply(4'b0000, 8'h7F, 8'h01, 1'b0);
    compare("R4", {8'h80, 1'b0, 1'b0});
    apply(4'b1000, 8'h01, 8'h01, 1'b0);
    compare("R4", {8'h00, 1'b1, 1'b1});

    // R11: every one-hot set and inverted-mask clear position
    for (int k = 0; k < 8; k++) begin
      logic [7:0] m;
      m = 8'h01 << k;
      apply(4'b0010, m, 8'h00, 1'b0);
      compare("R11", {m, 1'b0, 1'b0});
      apply(4'b0001, ~m, 8'hFF, 1'b1);
      compare("R11", {~m, 1'b1, 1'b0});
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule